// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio N = B·P + A. It is meant for the feedback path of a frequency synthesizer, where its output pulse goes to a phase detector. It is built from a dual-modulus prescaler that divides by P or P+1, a swallow counter (A) and a main counter (B). In every output period the prescaler runs at P+1 for the first A of its cycles and at P for the other B−A. When the main count runs out, both counters reload and one output pulse is emitted.

A 2-bit code picks the prescaler pair: 8/9, 16/17, 32/33 or 64/65. New A, B and code values are taken in only at a period boundary, so a running period is never cut short. The block also takes them in whenever it is idle. It is idle while the enable is low or while the held settings are invalid. Settings are valid only when B ≥ A and B ≥ 3. With invalid settings the error flag is set and the output stays low.

Top module: `ndiv_dual_mod`

## Requirements
- R1: With en high and valid settings, div_out pulses once every N = B·P + A input clocks, where P is the lower prescaler ratio.
- R2: ps_sel selects P as follows: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R3: In each output period, mod_hi is high for exactly A·(P+1) input clocks, and those clocks come first in the period. mod_hi rises only at a reload.
- R4: div_out is high for exactly one input clock per period.
- R5: Changes to a_val, b_val or ps_sel during a running period do not alter that period. They apply from the next boundary.
- R6: When the held settings have B < A or B < 3, cfg_err is high and div_out stays low. The new settings are taken in on the next clock.
- R7: While en is low, div_out is low and the counters track the inputs. The first pulse after en rises appears N clocks after the first enabled edge.
- R8: During reset, div_out and mod_hi are low and cfg_err is high, because the cleared settings are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Divider enable |
| a_val | input | 6 | Swallow count A |
| b_val | input | 12 | Main count B |
| ps_sel | input | 2 | Prescaler pair select |
| div_out | output | 1 | Divided pulse, one clock wide |
| mod_hi | output | 1 | High while the prescaler divides by P+1 |
| cfg_err | output | 1 | Held settings are invalid |

## Verification
The assertions assume that en and the setting inputs change only between clock edges. They also assume that any setting with B ≥ 3 gives a period longer than one clock, so a pulse can never be followed by another pulse at once. The stimulus meets these assumptions by driving every input on the falling edge. Random settings keep A small and B close to A so that many periods fit in the run. A few are made deliberately invalid with B = A−1, and directed cases cover the minimum B, B equal to A, the largest B and changes made in the middle of a period.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;
    // Prescaler pair codes; lower ratio is 2**(PMIN_LOG2 + code)
    typedef enum logic [1:0] {
        PS_LO8  = 2'b00,
        PS_LO16 = 2'b01,
        PS_LO32 = 2'b10,
        PS_LO64 = 2'b11
    } ndiv_ps_e;

    localparam int unsigned NDIV_PMIN_LOG2 = 3;
    localparam int unsigned NDIV_B_MIN     = 3;
endpackage

// File: rtl/nd_cfg_reg.sv
module nd_cfg_reg #(
    parameter int unsigned A_W   = 6,
    parameter int unsigned B_W   = 12,
    parameter int unsigned PS_W  = 2,
    parameter int unsigned B_MIN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [A_W-1:0]  a_in,
    input  logic [B_W-1:0]  b_in,
    input  logic [PS_W-1:0] ps_in,
    output logic [A_W-1:0]  a_q,
    output logic [B_W-1:0]  b_q,
    output logic [PS_W-1:0] ps_q,
    output logic            valid
);
    typedef struct packed {
        logic [A_W-1:0]  a;
        logic [B_W-1:0]  b;
        logic [PS_W-1:0] ps;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.a  = a_in;
            st_d.b  = b_in;
            st_d.ps = ps_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_q   = st_q.a;
    assign b_q   = st_q.b;
    assign ps_q  = st_q.ps;
    assign valid = (st_q.b >= B_W'(B_MIN)) && ({{(B_W-A_W){1'b0}}, st_q.a} <= st_q.b);
endmodule

// File: rtl/nd_prescaler.sv
module nd_prescaler #(
    parameter int unsigned PS_W      = 2,
    parameter int unsigned PMIN_LOG2 = 3,
    parameter int unsigned PC_W      = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic [PS_W-1:0] ps,
    input  logic            hi,
    output logic            tick
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PC_W-1:0] span;

    // Reload value is the segment length minus one: P-1, or P for P+1
    always_comb begin
        span = ({{(PC_W-1){1'b0}}, 1'b1} << (PMIN_LOG2 + 32'(ps))) - PC_W'(1) + PC_W'(hi);
    end

    always_comb begin
        st_d = st_q;
        if (reload || st_q.pc == '0) st_d.pc = span;
        else                         st_d.pc = st_q.pc - PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.pc == '0);
endmodule

// File: rtl/nd_swallow_main.sv
module nd_swallow_main #(
    parameter int unsigned A_W = 6,
    parameter int unsigned B_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           tick,
    input  logic [A_W-1:0] a_new,
    input  logic [B_W-1:0] b_new,
    output logic           last,
    output logic           hi_now,
    output logic           hi_next
);
    typedef struct packed {
        logic [A_W-1:0] ac;
        logic [B_W-1:0] bc;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ac = a_new;
            st_d.bc = b_new;
        end else if (tick) begin
            st_d.bc = st_q.bc - B_W'(1);
            if (st_q.ac != '0) st_d.ac = st_q.ac - A_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last    = tick && (st_q.bc == B_W'(1));
    assign hi_now  = (st_q.ac != '0);
    assign hi_next = (st_q.ac > A_W'(1));
endmodule

// File: rtl/ndiv_dual_mod.sv
module ndiv_dual_mod
    import ndiv_pkg::*;
#(
    parameter int unsigned A_W       = 6,
    parameter int unsigned B_W       = 12,
    parameter int unsigned PS_W      = 2,
    parameter int unsigned PMIN_LOG2 = NDIV_PMIN_LOG2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [A_W-1:0]  a_val,
    input  logic [B_W-1:0]  b_val,
    input  logic [PS_W-1:0] ps_sel,
    output logic            div_out,
    output logic            mod_hi,
    output logic            cfg_err
);
    localparam int unsigned PC_W = PMIN_LOG2 + (1 << PS_W);

    typedef struct packed {
        logic out;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [A_W-1:0]  a_q;
    logic [B_W-1:0]  b_q;
    logic [PS_W-1:0] ps_q;
    logic            cfg_ok;
    logic            run, last, load, tick;
    logic            hi_now, hi_next, pre_hi;
    logic [PS_W-1:0] pre_ps;

    always_comb begin
        run    = en && cfg_ok;
        load   = !run || last;
        pre_ps = load ? ps_sel : ps_q;
        pre_hi = load ? (a_val != '0) : hi_next;
        st_d.out = run && last;
    end

    nd_cfg_reg #(.A_W(A_W), .B_W(B_W), .PS_W(PS_W), .B_MIN(NDIV_B_MIN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .a_in(a_val), .b_in(b_val), .ps_in(ps_sel),
        .a_q(a_q), .b_q(b_q), .ps_q(ps_q), .valid(cfg_ok)
    );

    nd_prescaler #(.PS_W(PS_W), .PMIN_LOG2(PMIN_LOG2), .PC_W(PC_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .reload(load),
        .ps(pre_ps), .hi(pre_hi), .tick(tick)
    );

    nd_swallow_main #(.A_W(A_W), .B_W(B_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .tick(tick),
        .a_new(a_val), .b_new(b_val),
        .last(last), .hi_now(hi_now), .hi_next(hi_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_out = st_q.out;
    assign mod_hi  = hi_now;
    assign cfg_err = !cfg_ok;
endmodule

// File: rtl/ndiv_dual_mod_chk.sv
module ndiv_dual_mod_chk #(
    parameter int unsigned CFG_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             div_out,
    input logic             mod_hi,
    input logic             cfg_err,
    input logic             run,
    input logic             last,
    input logic             load,
    input logic [CFG_W-1:0] cfg_bits
);
    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R7
    en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !div_out);

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !div_out);

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> $stable(cfg_bits));

    // R3
    mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hi) |-> $past(load));
endmodule

bind ndiv_dual_mod ndiv_dual_mod_chk #(.CFG_W(A_W + B_W + PS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .div_out(div_out), .mod_hi(mod_hi),
    .cfg_err(cfg_err), .run(run), .last(last), .load(load),
    .cfg_bits({a_q, b_q, ps_q})
);

// File: tb/tb_ndiv_dual_mod.sv
`timescale 1ns/1ps
module tb_ndiv_dual_mod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [5:0]  a_val = '0;
    logic [11:0] b_val = '0;
    logic [1:0]  ps_sel = '0;
    logic        div_out, mod_hi, cfg_err;

    always #2.5 clk = ~clk;

    ndiv_dual_mod dut (
        .clk(clk), .rst_n(rst_n), .en(en), .a_val(a_val), .b_val(b_val),
        .ps_sel(ps_sel), .div_out(div_out), .mod_hi(mod_hi), .cfg_err(cfg_err)
    );

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 0;

    // reference model state
    int m_a = 0, m_b = 0, m_ps = 0, m_cnt = 0;
    bit e_out = 0, prev_out = 0, per_ok = 0;
    int hcnt = 0, hexp = 0;

    function automatic int p_of(int ps); return 8 << ps; endfunction
    function automatic bit ok_of(int a, int b); return (b >= a) && (b >= 3); endfunction
    function automatic int n_of(int a, int b, int ps); return b * p_of(ps) + a; endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_ps = 0; m_cnt = 0; e_out = 0; per_ok = 0;
        end else if (!(en && ok_of(m_a, m_b))) begin
            m_a = a_val; m_b = b_val; m_ps = ps_sel; m_cnt = 0; e_out = 0; per_ok = 0;
        end else begin
            m_cnt++;
            if (m_cnt == n_of(m_a, m_b, m_ps)) begin
                e_out = 1; m_a = a_val; m_b = b_val; m_ps = ps_sel; m_cnt = 0;
            end else e_out = 0;
        end
    endtask

    task automatic compare();
        check(cur_req, div_out, e_out);
        check("R6", cfg_err, !ok_of(m_a, m_b));
        if (prev_out) check("R4", div_out, 0);
        prev_out = div_out;
        if (!rst_n) check("R8", mod_hi, 0);
        if (e_out) begin
            if (per_ok) check("R3", hcnt, hexp);
            hexp = m_a * (p_of(m_ps) + 1);
            hcnt = mod_hi;
            per_ok = 1;
        end else hcnt += mod_hi;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic set_cfg(int a, int b, int ps);
        a_val = 6'(a); b_val = 12'(b); ps_sel = 2'(ps);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R8: reset state
        cur_req = "R8";
        run(3);
        check("R8", cfg_err, 1);
        check("R8", div_out, 0);
        @(negedge clk) rst_n = 1'b1;

        // R7: disabled, then enable
        cur_req = "R7";
        set_cfg(5, 10, 0);
        run(6);
        en = 1'b1;
        cur_req = "R1";
        run(3 * n_of(5, 10, 0) + 5);

        // R2: each prescaler code
        cur_req = "R2";
        for (int p = 0; p < 4; p++) begin
            set_cfg(3, 7, p);
            run(3 * n_of(3, 7, p) + 4);
        end

        // R1 corners: minimum B, B equal to A
        cur_req = "R1";
        set_cfg(0, 3, 1);  run(3 * n_of(0, 3, 1) + 4);
        set_cfg(9, 9, 0);  run(3 * n_of(9, 9, 0) + 4);

        // R6: invalid settings
        cur_req = "R6";
        set_cfg(0, 2, 0);  run(n_of(9, 9, 0) + 40);
        set_cfg(9, 8, 0);  run(40);

        // R5: change in the middle of a period
        cur_req = "R5";
        set_cfg(5, 10, 0); run(n_of(5, 10, 0) + 20);
        set_cfg(1, 4, 2);  run(30);
        set_cfg(2, 5, 1);  run(3 * n_of(2, 5, 1) + 20);

        // R7: disable in the middle of a run
        cur_req = "R7";
        run(17);
        en = 1'b0; run(25);
        en = 1'b1; run(2 * n_of(2, 5, 1) + 3);

        // random mix
        cur_req = "R1";
        for (int k = 0; k < 14; k++) begin
            int a, b, ps;
            a = 1 + ($urandom % 20);
            b = a + ($urandom % 11);
            if (b < 3) b = 3;
            if (k % 5 == 4) b = a - 1;
            ps = $urandom % 4;
            set_cfg(a, b, ps);
            run(ok_of(a, b) ? 3 * n_of(a, b, ps) + 10 : 30);
        end

        // largest main count
        set_cfg(63, 4095, 0);
        run(n_of(63, 4095, 0) + n_of(a_val, b_val, 0) + 10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule